// File: doc/BRIEF.md
# Static Memory Strobe Timing Generator

This block drives one asynchronous static memory device through a single chip select. A request port supplies a read or write command with an address and write data. The block then runs one bus access with the address, chip-select, read-strobe and write-strobe waveforms. When the access finishes, it raises a one-clock done pulse and presents the read data it captured. Strobes and chip select are active low.

The edges of the waveforms come from three configuration words: setup, pulse and cycle. A fourth word selects which signal times the read capture. The setup and pulse words each hold four coded fields, one each for the read strobe, the read-side chip select, the write strobe and the write-side chip select. The cycle word holds one coded field for reads and one for writes. The codes are nonlinear. A high-order bit adds a large fixed step to a small linear count. The block expands every code into a clock count when it starts an access, and it keeps those counts for the whole access.

The block does not check the programmed values. If setup plus pulse is larger than cycle for any signal, the result is undefined.

Top module: `smem_strobe_gen`

## Requirements
- R1: After reset, all strobe outputs and the chip select are high and req_ready is 1. Every setup field and every pulse field holds 1, both cycle fields hold 3, and mode bit 0 is 0. An access that starts with no configuration write therefore lasts 3 clocks, with the active signals low only in the second clock.
- R2: A setup code s[5:0] means 128*s[5] + s[4:0] clocks.
- R3: A pulse code p[6:0] means 256*p[6] + p[5:0] clocks.
- R4: A cycle code c[8:0] means 256*c[8:7] + c[6:0] clocks, with a minimum of 1. The access occupies exactly that many clocks, counted from the clock after acceptance. done is high for exactly the one clock that follows.
- R5: Number the access clocks k = 0, 1, 2 and so on. Each active signal is low exactly for setup <= k < setup+pulse, using its own fields. The chip select uses the read-side fields on reads and the write-side fields on writes. The read strobe goes low only on reads, and the write strobe only on writes.
- R6: mem_addr holds the request address in every access clock and is 0 when idle. mem_wdata holds the request data in every clock of a write and is 0 otherwise.
- R7: On a read, rd_data captures mem_rdata on the clock edge where the timing signal returns high. That edge ends access clock setup+pulse-1. The timing signal is the read strobe when mode bit 0 is 0, and the chip select when it is 1. If its pulse is 0, rd_data keeps its previous value.
- R8: req_ready equals "idle". A request is taken only when req_ready is 1, and requests presented during an access are ignored. A request may be taken in the same clock that done is high.
- R9: A configuration write takes effect only at the start of the next access. Changing a word during an access does not alter the access in progress.
- R10: Register map on cfg_addr:
  - 0 is setup. Fields are at bits [5:0] read strobe, [13:8] read chip select, [21:16] write strobe and [29:24] write chip select.
  - 1 is pulse. The same four signals are at bits [6:0], [14:8], [22:16] and [30:24].
  - 2 is cycle. The read field is at bits [8:0] and the write field at bits [24:16].
  - 3 is mode, bit 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block idle, request can be taken |
| done | output | 1 | One-clock end-of-access pulse |
| rd_data | output | DATA_W | Last captured read data |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest cases to reach from the ports are the large steps of the coded fields, where the high bit adds 128, 256 or more clocks. These can only be observed by running accesses hundreds of clocks long. The stimulus table therefore includes two such accesses. The bench compares every clock of each waveform against windows it computes from its own decoding.

The read capture edge is pinned by changing mem_rdata to a value unique to each clock. A configuration change during an access is hard to separate from one made between accesses. To reach it, the bench writes the cycle word in the middle of an access and then checks the lengths of both that access and the next one.

// File: rtl/smem_pkg.sv
`timescale 1ns/1ps
package smem_pkg;
  localparam int SETUP_W = 6;
  localparam int PULSE_W = 7;
  localparam int CYCLE_W = 9;
  localparam int CNT_W   = 10;
  localparam int N_CHAN  = 4;   // 0 rd strobe, 1 rd cs, 2 wr strobe, 3 wr cs

  localparam logic [SETUP_W-1:0] SETUP_RST = SETUP_W'(1);
  localparam logic [PULSE_W-1:0] PULSE_RST = PULSE_W'(1);
  localparam logic [CYCLE_W-1:0] CYCLE_RST = CYCLE_W'(3);

  // 128*c[5] + c[4:0]
  function automatic logic [CNT_W-1:0] dec_setup(input logic [SETUP_W-1:0] c);
    return {2'b00, c[5], 2'b00, c[4:0]};
  endfunction

  // 256*c[6] + c[5:0]
  function automatic logic [CNT_W-1:0] dec_pulse(input logic [PULSE_W-1:0] c);
    return {1'b0, c[6], 2'b00, c[5:0]};
  endfunction

  // 256*c[8:7] + c[6:0]
  function automatic logic [CNT_W-1:0] dec_cycle(input logic [CYCLE_W-1:0] c);
    return {c[8:7], 1'b0, c[6:0]};
  endfunction
endpackage

// File: rtl/smem_cfg_regs.sv
`timescale 1ns/1ps
module smem_cfg_regs
  import smem_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_wr,
  input  logic [1:0]                          cfg_addr,
  input  logic [31:0]                         cfg_wdata,
  output logic [N_CHAN-1:0][SETUP_W-1:0]      setup_f,
  output logic [N_CHAN-1:0][PULSE_W-1:0]      pulse_f,
  output logic [1:0][CYCLE_W-1:0]             cycle_f,
  output logic                                by_cs
);
  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31], cfg_wdata[23], cfg_wdata[15], cfg_wdata[7]};

  for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        setup_f[i] <= SETUP_RST;
        pulse_f[i] <= PULSE_RST;
      end else if (cfg_wr) begin
        if (cfg_addr == 2'd0) setup_f[i] <= cfg_wdata[8*i +: SETUP_W];
        if (cfg_addr == 2'd1) pulse_f[i] <= cfg_wdata[8*i +: PULSE_W];
      end
    end
  end

  for (genvar j = 0; j < 2; j++) begin : g_cyc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cycle_f[j] <= CYCLE_RST;
      else if (cfg_wr && cfg_addr == 2'd2)  cycle_f[j] <= cfg_wdata[16*j +: CYCLE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          by_cs <= 1'b0;
    else if (cfg_wr && cfg_addr == 2'd3) by_cs <= cfg_wdata[0];
  end
endmodule

// File: rtl/smem_field_decode.sv
`timescale 1ns/1ps
module smem_field_decode
  import smem_pkg::*;
(
  input  logic [N_CHAN-1:0][SETUP_W-1:0] setup_f,
  input  logic [N_CHAN-1:0][PULSE_W-1:0] pulse_f,
  input  logic [1:0][CYCLE_W-1:0]        cycle_f,
  output logic [N_CHAN-1:0][CNT_W-1:0]   setup_n,
  output logic [N_CHAN-1:0][CNT_W-1:0]   pulse_n,
  output logic [1:0][CNT_W-1:0]          cycle_n
);
  for (genvar i = 0; i < N_CHAN; i++) begin : g_dec
    assign setup_n[i] = dec_setup(setup_f[i]);
    assign pulse_n[i] = dec_pulse(pulse_f[i]);
  end
  for (genvar j = 0; j < 2; j++) begin : g_cyc
    assign cycle_n[j] = dec_cycle(cycle_f[j]);
  end
endmodule

// File: rtl/smem_win.sv
`timescale 1ns/1ps
module smem_win #(
  parameter int CNT_W = 10
) (
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] setup,
  input  logic [CNT_W-1:0] pulse,
  output logic             active,
  output logic             closing
);
  logic [CNT_W:0] stop;
  assign stop    = {1'b0, setup} + {1'b0, pulse};
  assign active  = en && ({1'b0, cnt} >= {1'b0, setup}) && ({1'b0, cnt} < stop);
  assign closing = en && (pulse != '0) && ({1'b0, cnt} == stop - 1'b1);
endmodule

// File: rtl/smem_strobe_gen.sv
`timescale 1ns/1ps
module smem_strobe_gen
  import smem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n
);
  logic [N_CHAN-1:0][SETUP_W-1:0] setup_f;
  logic [N_CHAN-1:0][PULSE_W-1:0] pulse_f;
  logic [1:0][CYCLE_W-1:0]        cycle_f;
  logic                           by_cs;
  logic [N_CHAN-1:0][CNT_W-1:0]   setup_n;
  logic [N_CHAN-1:0][CNT_W-1:0]   pulse_n;
  logic [1:0][CNT_W-1:0]          cycle_n;

  smem_cfg_regs u_regs (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata,
    .setup_f, .pulse_f, .cycle_f, .by_cs
  );

  smem_field_decode u_dec (
    .setup_f, .pulse_f, .cycle_f, .setup_n, .pulse_n, .cycle_n
  );

  // access state and snapshot of decoded timing
  logic              busy_q, op_wr_q, by_cs_q, done_q;
  logic [CNT_W-1:0]  cnt_q, last_q;
  logic [CNT_W-1:0]  st_setup_q, st_pulse_q, cs_setup_q, cs_pulse_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  // named internal events
  logic             acc_start, acc_last, rd_capture;
  logic             st_act, st_close, cs_act, cs_close;
  logic [CNT_W-1:0] sel_cycle;

  assign acc_start = req_valid && !busy_q;
  assign acc_last  = busy_q && (cnt_q == last_q);
  assign sel_cycle = cycle_n[req_write];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      op_wr_q    <= 1'b0;
      by_cs_q    <= 1'b0;
      done_q     <= 1'b0;
      cnt_q      <= '0;
      last_q     <= '0;
      st_setup_q <= '0;
      st_pulse_q <= '0;
      cs_setup_q <= '0;
      cs_pulse_q <= '0;
      addr_q     <= '0;
      wdata_q    <= '0;
    end else begin
      done_q <= acc_last;
      if (acc_start) begin
        busy_q     <= 1'b1;
        cnt_q      <= '0;
        op_wr_q    <= req_write;
        by_cs_q    <= by_cs;
        st_setup_q <= setup_n[req_write ? 2 : 0];
        st_pulse_q <= pulse_n[req_write ? 2 : 0];
        cs_setup_q <= setup_n[req_write ? 3 : 1];
        cs_pulse_q <= pulse_n[req_write ? 3 : 1];
        last_q     <= (sel_cycle == '0) ? '0 : sel_cycle - 1'b1;
        addr_q     <= req_addr;
        wdata_q    <= req_wdata;
      end else if (busy_q) begin
        if (acc_last) busy_q <= 1'b0;
        else          cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  smem_win #(.CNT_W(CNT_W)) u_win_st (
    .en(busy_q), .cnt(cnt_q), .setup(st_setup_q), .pulse(st_pulse_q),
    .active(st_act), .closing(st_close)
  );

  smem_win #(.CNT_W(CNT_W)) u_win_cs (
    .en(busy_q), .cnt(cnt_q), .setup(cs_setup_q), .pulse(cs_pulse_q),
    .active(cs_act), .closing(cs_close)
  );

  assign rd_capture = !op_wr_q && (by_cs_q ? cs_close : st_close);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (rd_capture) rdata_q <= mem_rdata;
  end

  assign req_ready = !busy_q;
  assign done      = done_q;
  assign rd_data   = rdata_q;
  assign mem_addr  = busy_q ? addr_q : '0;
  assign mem_wdata = (busy_q && op_wr_q) ? wdata_q : '0;
  assign mem_cs_n  = !cs_act;
  assign mem_rd_n  = !(st_act && !op_wr_q);
  assign mem_wr_n  = !(st_act && op_wr_q);
endmodule

// File: rtl/smem_strobe_gen_chk.sv
`timescale 1ns/1ps
module smem_strobe_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              acc_last,
  input logic              op_wr,
  input logic              done,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_rd_n,
  input logic              mem_wr_n
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_rd_n && mem_wr_n)); // R5

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last |=> (done && req_ready)); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !acc_last) |=> $stable(mem_addr)); // R6

  AST_STROBE_BY_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!mem_rd_n && !op_wr, !mem_wr_n && op_wr}) == $countones({!mem_rd_n, !mem_wr_n})); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !$past(done) || $past(busy)); // R8
endmodule

bind smem_strobe_gen smem_strobe_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .acc_last(acc_last), .op_wr(op_wr_q),
  .done(done), .req_ready(req_ready), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n)
);

// File: tb/smem_strobe_gen_tb.sv
`timescale 1ns/1ps
module smem_strobe_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic        req_ready, done, mem_cs_n, mem_rd_n, mem_wr_n;
  logic [15:0] rd_data, mem_addr, mem_wdata;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] prev_rd = '0;

  always #2.5 clk = ~clk;

  smem_strobe_gen u_dut (
    .clk, .rst_n, .cfg_wr, .cfg_addr, .cfg_wdata, .req_valid, .req_write,
    .req_addr, .req_wdata, .req_ready, .done, .rd_data, .mem_addr,
    .mem_wdata, .mem_rdata, .mem_cs_n, .mem_rd_n, .mem_wr_n
  );

  // stimulus table: write flag, setup, pulse, cycle, mode
  localparam int NV = 7;
  localparam logic        V_WR [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] V_SU [NV] = '{32'h01010101, 32'h00000002, 32'h00000002,
                                         32'h00010000, 32'h00002021, 32'h03200000, 32'h00000000};
  localparam logic [31:0] V_PU [NV] = '{32'h01010101, 32'h00000603, 32'h00000603,
                                         32'h07040000, 32'h00004241, 32'h45400000, 32'h00000100};
  localparam logic [31:0] V_CY [NV] = '{32'h00030003, 32'h00000008, 32'h00000008,
                                         32'h00090000, 32'h00000190, 32'h01050000, 32'h00000001};
  localparam logic [31:0] V_MD [NV] = '{32'h0, 32'h0, 32'h1, 32'h0, 32'h0, 32'h0, 32'h0};

  function automatic int e_setup(input int c);
    return ((c >> 5) & 1) * 128 + (c & 31);
  endfunction
  function automatic int e_pulse(input int c);
    return ((c >> 6) & 1) * 256 + (c & 63);
  endfunction
  function automatic int e_cycle(input int c);
    return ((c >> 7) & 3) * 256 + (c & 127);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after the done clock
  task automatic run_access(input bit w, input logic [15:0] a, input logic [15:0] d,
                            input logic [31:0] su, input logic [31:0] pu,
                            input logic [31:0] cy, input logic [31:0] md,
                            input bit mid, input logic [31:0] mid_cy);
    int sh_st, sh_cs, ss, sp, cs_s, cs_p, cyc, done_k, wave_bad, hold_bad, rdy_bad, bad_k;
    int close_k;
    logic [15:0] exp_rd;
    sh_st = w ? 16 : 0;
    sh_cs = w ? 24 : 8;
    ss   = e_setup(int'((su >> sh_st) & 32'h3F));
    sp   = e_pulse(int'((pu >> sh_st) & 32'h7F));
    cs_s = e_setup(int'((su >> sh_cs) & 32'h3F));
    cs_p = e_pulse(int'((pu >> sh_cs) & 32'h7F));
    cyc  = e_cycle(int'((cy >> (w ? 16 : 0)) & 32'h1FF));
    if (cyc == 0) cyc = 1;
    done_k = -1; wave_bad = 0; hold_bad = 0; rdy_bad = 0; bad_k = -1;

    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    // keep a conflicting request up during the access: must be ignored (R8)
    req_write = !w; req_addr = ~a; req_wdata = ~d;
    for (int k = 0; k < 2000; k++) begin
      bit e_cs, e_st, e_rd, e_wr;
      if (done) begin done_k = k; break; end
      e_cs = !((k >= cs_s) && (k < cs_s + cs_p));
      e_st = !((k >= ss) && (k < ss + sp));
      e_rd = w ? 1'b1 : e_st;
      e_wr = w ? e_st : 1'b1;
      if (mem_cs_n !== e_cs || mem_rd_n !== e_rd || mem_wr_n !== e_wr) begin
        wave_bad++;
        if (bad_k < 0) bad_k = k;
      end
      if (mem_addr !== a || mem_wdata !== (w ? d : 16'h0)) hold_bad++;
      if (req_ready !== 1'b0) rdy_bad++;
      if (k == cyc - 1) req_valid = 1'b0;
      if (mid && k == 1) begin cfg_wr = 1'b1; cfg_addr = 2'd2; cfg_wdata = mid_cy; end
      if (mid && k == 2) cfg_wr = 1'b0;
      mem_rdata = 16'h4000 + 16'(k);
      @(negedge clk);
    end
    check(done_k == cyc, w ? "R4 write" : "R4 read", "access length", done_k, cyc);
    check(wave_bad == 0, "R5", "waveform mismatching clocks (first k shown)", bad_k, -1);
    check(hold_bad == 0, "R6", "addr/wdata hold violations", hold_bad, 0);
    check(rdy_bad == 0, "R8", "req_ready high during access", rdy_bad, 0);
    if (!w) begin
      close_k = md[0] ? ((cs_p > 0) ? cs_s + cs_p - 1 : -1)
                      : ((sp > 0) ? ss + sp - 1 : -1);
      exp_rd = (close_k < 0) ? prev_rd : 16'h4000 + 16'(close_k);
      check(rd_data === exp_rd, "R7", "rd_data", int'(rd_data), int'(exp_rd));
      prev_rd = exp_rd;
    end
    @(negedge clk);
    check(done === 1'b0 && mem_cs_n === 1'b1 && mem_addr === 16'h0 && req_ready === 1'b1,
          "R4 R6", "idle after done", int'(done), 0);
  endtask

  initial begin
    #(5 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mem_cs_n && mem_rd_n && mem_wr_n && req_ready && !done, "R1",
          "reset outputs", int'({mem_cs_n, mem_rd_n, mem_wr_n, req_ready, done}), 5'b11110);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: defaults with no configuration write: 3 clocks, low only in k=1
    run_access(1'b0, 16'h0123, 16'h0, 32'h01010101, 32'h01010101, 32'h00030003, 0, 0, 0);
    run_access(1'b1, 16'h0456, 16'hBEEF, 32'h01010101, 32'h01010101, 32'h00030003, 0, 0, 0);

    // table walk: R2 R3 R4 R5 R7 R10 (large codes in entries 4 and 5)
    for (int v = 0; v < NV; v++) begin
      cfg_write(2'd0, V_SU[v]);
      cfg_write(2'd1, V_PU[v]);
      cfg_write(2'd2, V_CY[v]);
      cfg_write(2'd3, V_MD[v]);
      run_access(V_WR[v], 16'h1000 + 16'(v), 16'hA5A0 + 16'(v),
                 V_SU[v], V_PU[v], V_CY[v], V_MD[v], 0, 0);
    end

    // R9: cycle word changed mid-access; current keeps 8, next uses 12
    cfg_write(2'd0, 32'h00000002);
    cfg_write(2'd1, 32'h00000603);
    cfg_write(2'd2, 32'h00000008);
    cfg_write(2'd3, 32'h0);
    run_access(1'b0, 16'h2222, 16'h0, 32'h00000002, 32'h00000603, 32'h00000008, 0, 1, 32'h0000000C);
    run_access(1'b0, 16'h3333, 16'h0, 32'h00000002, 32'h00000603, 32'h0000000C, 0, 0, 0);

    // R8: back-to-back request presented in the done clock is taken
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h5555;
    @(negedge clk);
    check(req_ready === 1'b0 && mem_addr === 16'h5555, "R8", "accept",
          int'(mem_addr), 16'h5555);
    req_valid = 1'b0;
    repeat (12) @(negedge clk);
    check(done === 1'b1 && req_ready === 1'b1, "R8", "done/ready", int'(done), 1);
    req_valid = 1'b1; req_addr = 16'h6666;
    @(negedge clk);
    check(mem_addr === 16'h6666, "R8", "accept in done clock", int'(mem_addr), 16'h6666);
    req_valid = 1'b0;
    repeat (14) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule